// File: doc/BRIEF.md
# LED Panel Row Handoff Sequencer

This block runs the short gap between two row bursts of a multiplexed LED panel. A separate burst generator shifts one row of pixel data into the panel and stops its shift clock. It then pulses `row_done` for one clock. The sequencer blanks the panel and pulses the latch. It moves the two row-address lines to the next row and waits for them to settle. It pulses the latch a second time to capture the shifted data. Last, it re-enables the output and sends a one-clock restart to the burst generator, so that the next row burst begins.

The latch pulse width and the address settle time are each given in system clocks on input ports. Both are captured when a sequence is accepted. The current row is kept in a register that counts modulo `ROWS`, which is at most 4 because there are two address lines. Pixel data, shift clocking and brightness modulation are outside this block.

Top module: `led_row_handoff`

## Requirements
- R1: While reset is asserted and after it is released, `lat`, `oe_n`, `row_a`, `row_b` and `burst_restart` are all 0 until a `row_done` is accepted.
- R2: A `row_done` sampled high while idle starts a sequence. From the next clock, `oe_n` and `lat` are both 1 for H cycles, where H is the captured `hold_cycles`.
- R3: After the first latch pulse, `lat` is 0 and `oe_n` stays 1 for S cycles, where S is the captured `settle_cycles`. The row address takes its new value in the first of these cycles.
- R4: After the settle step, `lat` is 1 again for H cycles while `oe_n` stays 1 and the row address is unchanged.
- R5: After the second latch pulse, `burst_restart` is 1 for exactly one cycle with `oe_n` 0 and `lat` 0. The block is then idle again with all three lines at 0.
- R6: A `row_done` that arrives between acceptance and the end of the restart cycle is ignored. It does not lengthen or restart the sequence.
- R7: A programmed value of 0 for `hold_cycles` or `settle_cycles` acts as 1.
- R8: The row index is presented as `row_a` = bit 0 and `row_b` = bit 1. It advances by one per sequence and wraps from `ROWS-1` to 0 (3 to 0 by default).
- R9: `lat` is never 1 while `oe_n` is 0, and the row address only changes while `oe_n` has been 1 for at least one cycle.
- R10: Changes to `hold_cycles` or `settle_cycles` after a sequence is accepted do not affect that sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_done | input | 1 | Row burst finished, shift clock stopped |
| hold_cycles | input | CNT_W | Latch pulse width in clocks (0 acts as 1) |
| settle_cycles | input | CNT_W | Address settle time in clocks (0 acts as 1) |
| lat | output | 1 | Panel latch strobe, active high |
| oe_n | output | 1 | Panel output enable, active low |
| row_a | output | 1 | Row address bit 0 |
| row_b | output | 1 | Row address bit 1 |
| burst_restart | output | 1 | One-clock restart to the burst clock generator |

## Verification
Every output is decoded directly from the phase register and the row register. A wrong phase or a miscounted step therefore shows on `lat`, `oe_n` or `burst_restart` in the very cycle it occurs, as a latch edge or restart that is early or late. A wrong row index shows on `row_a`/`row_b` from the first settle cycle of the sequence in which it goes wrong, and it stays wrong for every later row. A done pulse that was wrongly accepted shows one cycle later, as blanking or latching where idle outputs were expected.

// File: rtl/led_row_handoff.sv
module led_row_handoff #(
  parameter int CNT_W = 8,
  parameter int ROWS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_done,
  input  logic [CNT_W-1:0] hold_cycles,
  input  logic [CNT_W-1:0] settle_cycles,
  output logic             lat,
  output logic             oe_n,
  output logic             row_a,
  output logic             row_b,
  output logic             burst_restart
);
  localparam int RW = 2;
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_BLANK, ST_ADDR, ST_LATCH, ST_GO} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] cnt, hold_q, settle_q;
  logic [RW-1:0]    row;

  wire [CNT_W-1:0] hold_m1   = (hold_cycles   == '0) ? '0 : hold_cycles   - CNT_W'(1);
  wire [CNT_W-1:0] settle_m1 = (settle_cycles == '0) ? '0 : settle_cycles - CNT_W'(1);
  wire             cnt_end   = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= ST_IDLE;
      cnt      <= '0;
      hold_q   <= '0;
      settle_q <= '0;
      row      <= '0;
    end else begin
      case (phase)
        ST_IDLE: if (row_done) begin
          hold_q   <= hold_m1;
          settle_q <= settle_m1;
          cnt      <= hold_m1;
          phase    <= ST_BLANK;
        end
        ST_BLANK: if (cnt_end) begin
          cnt   <= settle_q;
          row   <= (row == LAST_ROW) ? '0 : row + RW'(1);
          phase <= ST_ADDR;
        end else cnt <= cnt - CNT_W'(1);
        ST_ADDR: if (cnt_end) begin
          cnt   <= hold_q;
          phase <= ST_LATCH;
        end else cnt <= cnt - CNT_W'(1);
        ST_LATCH: if (cnt_end) phase <= ST_GO;
                  else cnt <= cnt - CNT_W'(1);
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign lat           = (phase == ST_BLANK) || (phase == ST_LATCH);
  assign oe_n          = (phase == ST_BLANK) || (phase == ST_ADDR) || (phase == ST_LATCH);
  assign burst_restart = (phase == ST_GO);
  assign row_a         = row[0];
  assign row_b         = row[1];
endmodule

// File: rtl/led_row_handoff_chk.sv
module led_row_handoff_chk #(
  parameter int ROWS = 4
) (
  input logic clk,
  input logic rst_n,
  input logic lat,
  input logic oe_n,
  input logic row_a,
  input logic row_b,
  input logic burst_restart
);
  wire [1:0] row = {row_b, row_a};

  assert_lat_blanked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lat |-> oe_n);

  assert_row_moves_blanked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (row != $past(row)) |-> (oe_n && $past(oe_n)));

  assert_row_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (row != $past(row)) |-> (row == (($past(row) == 2'(ROWS - 1)) ? 2'd0 : $past(row) + 2'd1)));

  assert_restart_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_restart |=> !burst_restart);

  assert_restart_after_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_restart) |-> ($past(lat) && !lat && !oe_n));

  assert_latch_holds_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lat) && $past(oe_n)) |-> $stable(row));
endmodule

bind led_row_handoff led_row_handoff_chk #(.ROWS(ROWS)) chk (
  .clk(clk), .rst_n(rst_n), .lat(lat), .oe_n(oe_n),
  .row_a(row_a), .row_b(row_b), .burst_restart(burst_restart)
);

// File: tb/led_row_handoff_test.sv
module led_row_handoff_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int ROWS  = 4;

  logic clk = 0, rst_n = 0, row_done = 0;
  logic [CNT_W-1:0] hold_cycles = 0, settle_cycles = 0;
  logic lat, oe_n, row_a, row_b, burst_restart;
  int vectors = 0, errors = 0, exp_row = 0;
  bit done_flag = 0;

  led_row_handoff #(.CNT_W(CNT_W), .ROWS(ROWS)) uut (
    .clk(clk), .rst_n(rst_n), .row_done(row_done),
    .hold_cycles(hold_cycles), .settle_cycles(settle_cycles),
    .lat(lat), .oe_n(oe_n), .row_a(row_a), .row_b(row_b),
    .burst_restart(burst_restart)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected {restart, oe_n, lat, row_b, row_a} at cycle t after acceptance
  function automatic logic [4:0] expect_at(int t, int h, int s, int r_old);
    int r_new = (r_old + 1) % ROWS;
    if (t <= h)               return {3'b011, 2'(r_old)};
    if (t <= h + s)           return {3'b010, 2'(r_new)};
    if (t <= 2*h + s)         return {3'b011, 2'(r_new)};
    if (t == 2*h + s + 1)     return {3'b100, 2'(r_new)};
    return {3'b000, 2'(r_new)};
  endfunction

  function automatic string phase_req(int t, int h, int s);
    if (t <= h)           return "R2";
    if (t <= h + s)       return "R3";
    if (t <= 2*h + s)     return "R4";
    return "R5";
  endfunction

  task automatic compare(logic [4:0] exp, string req);
    logic [4:0] act = {burst_restart, oe_n, lat, row_b, row_a};
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // one sequence; noise drives done pulses (R6) and setting changes (R10) mid-run
  task automatic run_seq(int h_prog, int s_prog, bit noise);
    int h = (h_prog == 0) ? 1 : h_prog;  // R7
    int s = (s_prog == 0) ? 1 : s_prog;
    int total = 2*h + s + 1;
    hold_cycles = CNT_W'(h_prog);
    settle_cycles = CNT_W'(s_prog);
    row_done = 1;
    @(negedge clk);
    row_done = 0;
    for (int t = 1; t <= total + 2; t++) begin
      compare(expect_at(t, h, s, exp_row),
              (t > total) ? "R6" : ((h_prog == 0 || s_prog == 0) ? "R7" : phase_req(t, h, s)));
      if (noise && t <= total) begin
        row_done = 1'($urandom_range(0, 1));
        hold_cycles = CNT_W'($urandom_range(0, 9));
        settle_cycles = CNT_W'($urandom_range(0, 9));
      end else row_done = 0;
      @(negedge clk);
    end
    exp_row = (exp_row + 1) % ROWS;  // R8
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    row_done = 1;  // ignored in reset (R1)
    repeat (4) @(negedge clk);
    compare(5'b00000, "R1");
    rst_n = 1;
    row_done = 0;
    repeat (3) begin
      @(negedge clk);
      compare(5'b00000, "R1");
    end
    run_seq(1, 1, 0);   // minimum lengths
    run_seq(0, 0, 0);   // R7 zero treated as one
    run_seq(3, 5, 1);   // R6 R10 noise
    run_seq(2, 0, 0);   // row index 3 -> wraps next (R8)
    if (exp_row != 0) begin errors++; $display("FAIL R8: actual %0d expected 0", exp_row); end
    run_seq(4, 2, 0);
    for (int i = 0; i < 300; i++)
      run_seq($urandom_range(0, 6), $urandom_range(0, 6), 1'($urandom_range(0, 1)));
    done_flag = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule